// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The block brings a wide bank of asynchronous GPIO pins into the clock domain and routes a chosen subset onto a smaller set of interrupt request lines. Every request line has its own programmable pin selector. The selected signal then goes through a per-line trigger stage, which produces either a level or a one-clock pulse for each qualifying transition.

Three control bits per line set the trigger behaviour:

- An inversion bit.
- A single-edge bit.
- A both-edge bit, which overrides the other two.

A single global enable gates all lines together. The parent interrupt controller programs the block through a plain word-addressed port. Writes take effect on the clock edge. Reads are combinational from the address.

Because edge history is kept per pin and not per line, re-routing a line never creates an edge that did not occur on a pin.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register word reads zero and every `irq_o` bit is low; each line is then disabled, active-high, level-sensitive and routed to pin 0.
- R2: Word 0 holds the per-line invert bits in bits 19..0 and the global enable in bit 31. Word 11 holds the both-edge bits in bits 19..0. Word 12 holds the single-edge bits in bits 19..0. Unused bits and words 13..15 read as zero, and writes to words 13..15 change nothing.
- R3: Word X (X = 1..10) holds the 6-bit selector of line 2X-2 in bits 5..0 and that of line 2X-1 in bits 21..16; a line follows the pin whose number equals its selector.
- R4: Each pin passes through two synchronising flops; in level mode a pin change made between clock edges reaches `irq_o` after exactly two rising edges.
- R5: In level mode (both-edge and single-edge bits clear) a line equals its synchronised pin when its invert bit is 0, and the inverse when it is 1.
- R6: In single-edge mode with the invert bit 0, a line pulses high for exactly one clock per rising transition of its pin. With the invert bit 1, it does so per falling transition.
- R7: With the both-edge bit set, a line pulses for one clock on every transition of its pin, whatever its invert and single-edge bits hold.
- R8: A selector value of 39 or more drives the line permanently low in every mode, including inverted level mode.
- R9: While the global enable is 0 every line is low; pin transitions made while disabled produce no pulse once the enable is set again.
- R10: Changing a line's selector in an edge mode produces no pulse unless the newly selected pin itself transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 39 | Asynchronous GPIO pin levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq_o | output | 20 | Interrupt request lines |

## Verification
The bench targets the override of both-edge mode. A design that checked polarity before both-edge would miss every other transition. It also drives out-of-range selectors with inversion set, since a design that only zeroed the pin would hold the line high. A pin is toggled while the block is disabled and the block is then re-enabled: per-line history that froze during the disable would emit a stray pulse. Selectors are also moved between pins at different levels in edge mode, which catches history kept per line instead of per pin. Readback of the split selector fields and the masked words exposes misplaced or unmasked bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // Register word indices and fixed bit positions shared by the block.
   localparam int unsigned WIDX_CTRL     = 0;
   localparam int unsigned WIDX_SEL_BASE = 1;
   localparam int unsigned EN_BIT        = 31;
   localparam int unsigned SEL_HI_LSB    = 16;

   typedef struct packed {
      logic inv;
      logic single;
      logic both;
   } trig_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned N_PINS = 39,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   output logic [N_PINS-1:0] now_o,
   output logic [N_PINS-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [N_PINS-1:0] stg_q [STAGES];
   logic [N_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= pin_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         // History always tracks the synchronised value, so it is fresh on re-enable.
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign now_o  = stg_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_LINES = 20,
   parameter int unsigned SEL_W   = 6,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic                     en_o,
   output logic [N_LINES-1:0]       inv_o,
   output logic [N_LINES-1:0]       single_o,
   output logic [N_LINES-1:0]       both_o,
   output logic [N_LINES*SEL_W-1:0] sel_o
);
   localparam int unsigned N_PAIRS     = N_LINES / 2;
   localparam int unsigned WIDX_BOTH   = WIDX_SEL_BASE + N_PAIRS;
   localparam int unsigned WIDX_SINGLE = WIDX_BOTH + 1;

   if (N_LINES % 2 != 0) begin : g_bad_pairs
      $error("gpio_irq_regs: N_LINES must be even");
   end
   if (N_LINES > EN_BIT) begin : g_bad_lines
      $error("gpio_irq_regs: line bits collide with the enable bit");
   end
   if (SEL_W > SEL_HI_LSB || SEL_HI_LSB + SEL_W > DATA_W) begin : g_bad_sel
      $error("gpio_irq_regs: selector fields do not fit a word");
   end
   if (WIDX_SINGLE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_irq_regs: ADDR_W too small for the register map");
   end

   logic                 en_q;
   logic [N_LINES-1:0]   inv_q, single_q, both_q;
   logic [SEL_W-1:0]     sel_q [N_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         inv_q    <= '0;
         single_q <= '0;
         both_q   <= '0;
         for (int i = 0; i < N_LINES; i++) sel_q[i] <= '0;
      end else if (we_i) begin
         if (addr_i == ADDR_W'(WIDX_CTRL)) begin
            inv_q <= wdata_i[N_LINES-1:0];
            en_q  <= wdata_i[EN_BIT];
         end
         if (addr_i == ADDR_W'(WIDX_BOTH))   both_q   <= wdata_i[N_LINES-1:0];
         if (addr_i == ADDR_W'(WIDX_SINGLE)) single_q <= wdata_i[N_LINES-1:0];
         for (int j = 0; j < N_PAIRS; j++) begin
            if (addr_i == ADDR_W'(WIDX_SEL_BASE + j)) begin
               sel_q[2*j]   <= wdata_i[SEL_W-1:0];
               sel_q[2*j+1] <= wdata_i[SEL_HI_LSB +: SEL_W];
            end
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(WIDX_CTRL)) begin
         rdata_o[N_LINES-1:0] = inv_q;
         rdata_o[EN_BIT]      = en_q;
      end
      if (addr_i == ADDR_W'(WIDX_BOTH))   rdata_o[N_LINES-1:0] = both_q;
      if (addr_i == ADDR_W'(WIDX_SINGLE)) rdata_o[N_LINES-1:0] = single_q;
      for (int j = 0; j < N_PAIRS; j++) begin
         if (addr_i == ADDR_W'(WIDX_SEL_BASE + j)) begin
            rdata_o[SEL_W-1:0]            = sel_q[2*j];
            rdata_o[SEL_HI_LSB +: SEL_W]  = sel_q[2*j+1];
         end
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_sel_out
      assign sel_o[i*SEL_W +: SEL_W] = sel_q[i];
   end

   assign en_o     = en_q;
   assign inv_o    = inv_q;
   assign single_o = single_q;
   assign both_o   = both_q;

   // R2: a control-word write lands in the enable on the next cycle
   a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADDR_W'(WIDX_CTRL)) |=> (en_o == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_PINS = 39,
   parameter int unsigned SEL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  trig_cfg_t         cfg_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [N_PINS-1:0] now_i,
   input  logic [N_PINS-1:0] prev_i,
   output logic              irq_o
);
   localparam int unsigned SPAN = 1 << SEL_W;

   if (N_PINS > SPAN) begin : g_bad_span
      $error("gpio_irq_line: SEL_W cannot address every pin");
   end

   logic [SPAN-1:0] now_pad, prev_pad;
   logic            valid, cur, old, hit;

   assign now_pad  = SPAN'(now_i);
   assign prev_pad = SPAN'(prev_i);
   assign valid    = 32'(sel_i) < 32'(N_PINS);
   assign cur      = now_pad[sel_i];
   assign old      = prev_pad[sel_i];

   always_comb begin
      if (!en_i || !valid)    hit = 1'b0;
      else if (cfg_i.both)    hit = cur ^ old;
      else if (cfg_i.single)  hit = cfg_i.inv ? (old & ~cur) : (cur & ~old);
      else                    hit = cur ^ cfg_i.inv;
   end

   assign irq_o = hit;

   // R6: a single-edge pulse never lasts two cycles while the routing is unchanged
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && cfg_i.single && !cfg_i.both)
      |=> !(irq_o && $stable(sel_i) && $stable(cfg_i)));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_PINS      = 39,
   parameter int unsigned N_LINES     = 20,
   parameter int unsigned SEL_W       = 6,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PINS-1:0]  gpio_i,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0]  cfg_rdata,
   output logic [N_LINES-1:0] irq_o
);
   logic                     en;
   logic [N_LINES-1:0]       inv, single, both;
   logic [N_LINES*SEL_W-1:0] sel_flat;
   logic [N_PINS-1:0]        pin_now, pin_prev;

   gpio_irq_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(gpio_i), .now_o(pin_now), .prev_o(pin_prev)
   );

   gpio_irq_regs #(.N_LINES(N_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
      .rdata_o(cfg_rdata), .en_o(en), .inv_o(inv), .single_o(single), .both_o(both),
      .sel_o(sel_flat)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      trig_cfg_t tcfg;
      assign tcfg = '{inv: inv[i], single: single[i], both: both[i]};

      gpio_irq_line #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_line (
         .clk(clk), .rst_n(rst_n), .en_i(en), .cfg_i(tcfg),
         .sel_i(sel_flat[i*SEL_W +: SEL_W]), .now_i(pin_now), .prev_i(pin_prev),
         .irq_o(irq_o[i])
      );

      // R8: an out-of-range selector keeps its line low
      a_r8_unrouted_low: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(sel_flat[i*SEL_W +: SEL_W]) >= 32'(N_PINS)) |-> !irq_o[i]);
   end

   // R9: global enable gates every line
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (irq_o == '0));
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 39;
   localparam int NL = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] gpio = '0;
   logic          we = 1'b0;
   logic [3:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NL-1:0] irq;

   int n_tests = 0;
   int n_fail  = 0;
   string cur_req = "R1";

   // behavioural reference state
   bit m_s1 [NP];
   bit m_s2 [NP];
   bit m_pv [NP];
   bit m_en;
   bit m_inv [NL];
   bit m_sgl [NL];
   bit m_bth [NL];
   int m_sel [NL];
   int sel_cfg [NL];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_router u_dut (
      .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .cfg_we(we), .cfg_addr(addr),
      .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_o(irq)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0;
         for (int i = 0; i < NP; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; end
         for (int i = 0; i < NL; i++) begin
            m_inv[i] = 0; m_sgl[i] = 0; m_bth[i] = 0; m_sel[i] = 0;
         end
      end else begin
         for (int i = 0; i < NP; i++) begin
            m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = gpio[i];
         end
         if (we) begin
            if (addr == 0) begin
               m_en = wdata[31];
               for (int i = 0; i < NL; i++) m_inv[i] = wdata[i];
            end else if (addr >= 1 && addr <= 10) begin
               m_sel[2*(addr-1)]   = int'(wdata[5:0]);
               m_sel[2*(addr-1)+1] = int'(wdata[21:16]);
            end else if (addr == 11) begin
               for (int i = 0; i < NL; i++) m_bth[i] = wdata[i];
            end else if (addr == 12) begin
               for (int i = 0; i < NL; i++) m_sgl[i] = wdata[i];
            end
         end
      end
   end

   function automatic bit expect_line(int i);
      int p;
      bit c, o;
      p = m_sel[i];
      if (!m_en || p >= NP) return 0;
      c = m_s2[p];
      o = m_pv[p];
      if (m_bth[i]) return c != o;
      if (m_sgl[i]) return m_inv[i] ? (o && !c) : (c && !o);
      return c != m_inv[i];
   endfunction

   task automatic check_bit(string req, string what, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // one clock, then compare every line against the model
   task automatic step();
      @(negedge clk);
      for (int i = 0; i < NL; i++) begin
         n_tests++;
         if (irq[i] !== expect_line(i)) begin
            n_fail++;
            $display("FAIL %s irq[%0d] t=%0t: actual %0b expected %0b",
                     cur_req, i, $time, irq[i], expect_line(i));
         end
      end
   endtask

   task automatic steps(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic wr(int a, logic [31:0] d);
      we = 1'b1; addr = 4'(a); wdata = d;
      step();
      we = 1'b0;
   endtask

   task automatic rd(string req, int a, logic [31:0] exp);
      addr = 4'(a);
      #1;
      n_tests++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read word %0d: actual %h expected %h", req, a, rdata, exp);
      end
   endtask

   task automatic push_sel();
      for (int x = 1; x <= 10; x++)
         wr(x, {10'd0, 6'(sel_cfg[2*x-1]), 10'd0, 6'(sel_cfg[2*x-2])});
   endtask

   task automatic wiggle(int n);
      for (int k = 0; k < n; k++) begin
         gpio[$urandom_range(NP-1, 0)] ^= 1'b1;
         if ((k % 3) == 0) gpio[$urandom_range(NP-1, 0)] ^= 1'b1;
         step();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      step();
      for (int a = 0; a <= 12; a++) rd("R1", a, 32'h0);
      check_bit("R1", "irq all low", |irq, 1'b0);

      // R2 readback masking and unmapped words
      cur_req = "R2";
      wr(0, 32'hFFFF_FFFF);  rd("R2", 0, 32'h800F_FFFF);
      wr(11, 32'hFFFF_FFFF); rd("R2", 11, 32'h000F_FFFF);
      wr(12, 32'hFFFF_FFFF); rd("R2", 12, 32'h000F_FFFF);
      wr(13, 32'hFFFF_FFFF); rd("R2", 13, 32'h0);
      wr(15, 32'hFFFF_FFFF); rd("R2", 15, 32'h0);
      rd("R2", 0, 32'h800F_FFFF);
      wr(0, 32'h0); wr(11, 32'h0); wr(12, 32'h0);

      // R3 split selector fields and routing
      cur_req = "R3";
      wr(1, 32'hFFFF_FFFF); rd("R3", 1, 32'h003F_003F);
      for (int i = 0; i < NL; i++) sel_cfg[i] = (i * 7 + 3) % NP;
      push_sel();
      rd("R3", 1, {10'd0, 6'(sel_cfg[1]), 10'd0, 6'(sel_cfg[0])});
      rd("R3", 10, {10'd0, 6'(sel_cfg[19]), 10'd0, 6'(sel_cfg[18])});
      wr(0, 32'h8000_0000);
      for (int p = 0; p < NP; p++) begin
         gpio = '0; gpio[p] = 1'b1;
         steps(3);
      end
      gpio = '0; steps(3);

      // R4 two-flop latency on line 0
      cur_req = "R4";
      gpio[sel_cfg[0]] = 1'b1;
      step(); check_bit("R4", "irq0 after 1 edge", irq[0], 1'b0);
      step(); check_bit("R4", "irq0 after 2 edges", irq[0], 1'b1);
      gpio = '0; steps(3);

      // R5 level mode with mixed inversion
      cur_req = "R5";
      wr(0, 32'h800A_5A5A);
      steps(3);
      check_bit("R5", "inverted line1 idle high", irq[1], 1'b1);
      check_bit("R5", "plain line0 idle low", irq[0], 1'b0);
      wiggle(300);

      // R6 single-edge, rising and falling
      cur_req = "R6";
      wr(12, 32'h000F_FFFF);
      wiggle(400);
      gpio[sel_cfg[0]] = ~gpio[sel_cfg[0]];
      steps(4);

      // R7 both-edge overrides polarity and single-edge
      cur_req = "R7";
      wr(11, 32'h000F_FFFF);
      wr(12, 32'h0003_3333);
      wiggle(400);
      gpio[sel_cfg[1]] = ~gpio[sel_cfg[1]];
      step(); step();
      check_bit("R7", "line1 pulse on transition", irq[1], 1'b1);
      step();
      check_bit("R7", "line1 pulse ends", irq[1], 1'b0);

      // R8 out-of-range selectors stay low, even inverted level mode
      cur_req = "R8";
      wr(11, 32'h0); wr(12, 32'h0);
      wr(0, 32'h800F_FFFF);
      sel_cfg[0] = 39; sel_cfg[1] = 63; sel_cfg[4] = 50; sel_cfg[7] = 40;
      push_sel();
      steps(2);
      check_bit("R8", "line0 sel 39", irq[0], 1'b0);
      check_bit("R8", "line1 sel 63", irq[1], 1'b0);
      wiggle(100);
      wr(11, 32'h000F_FFFF);
      wiggle(100);

      // R9 enable clear silences lines; no stale pulse on re-enable
      cur_req = "R9";
      for (int i = 0; i < NL; i++) sel_cfg[i] = (i * 5 + 1) % NP;
      push_sel();
      wr(0, 32'h000F_FFFF);
      wiggle(50);
      check_bit("R9", "disabled all low", |irq, 1'b0);
      gpio = ~gpio;
      steps(4);
      wr(0, 32'h8000_0000);
      check_bit("R9", "no pulse on re-enable", |irq, 1'b0);
      steps(3);

      // R10 reselection in edge mode without a pin edge
      cur_req = "R10";
      wr(11, 32'h0); wr(12, 32'h000F_FFFF);
      gpio = '0; gpio[2] = 1'b1; gpio[30] = 1'b1;
      steps(4);
      sel_cfg[0] = 2; sel_cfg[1] = 30; push_sel();
      check_bit("R10", "line0 moved to high pin", irq[0], 1'b0);
      steps(2);
      sel_cfg[0] = 5; sel_cfg[1] = 6; push_sel();
      wr(0, 32'h8000_0003);
      check_bit("R10", "line0 falling mode moved to low pin", irq[0], 1'b0);
      steps(2);
      wiggle(200);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule